// File: doc/BRIEF.md
# Counted Accumulator Shifter with Normalize

This block runs multi-cycle shifts on a 16-bit accumulator and the 16-bit extension word that sits to its right. A caller pulses `start_i` with an operation code, a 6-bit count and the current register values. The block then shifts one bit position per clock while a cycle-control counter counts down. When the run ends it pulses `done_o` for one cycle and presents the new accumulator, extension, carry and residual count. The caller writes these back.

There are five operations. Two are plain left shifts: one moves the accumulator alone and one moves the 32-bit pair. A normalize left shift of the pair stops early once the accumulator's top bit is 1. The last two are an arithmetic right shift of the pair and a rotate right of the pair. The count comes either from the low bits of the instruction displacement or from the low bits of an index register, as `use_reg_i` selects. Decode and register fetch happen outside the block.

The carry indicator follows the rules below. The overflow indicator passes through the block and no shift can change it.

Top module: `shift_seq_unit`

## Requirements
- R1: The count is `idx_cnt_i` when `use_reg_i` is 1 and `disp_cnt_i` when it is 0. It is sampled on the clock edge where `start_i` is high and `busy_o` is low.
- R2: Operation codes on `op_i` are: 0 = accumulator left, 1 = pair left, 2 = normalize, 3 = pair arithmetic right, 4 = pair rotate right. Each busy cycle either performs one shift and lowers the counter by one, or ends the run. `done_o` is high for exactly one cycle, s+1 clock edges after the accepting edge, where s is the number of shifts performed. `busy_o` and `done_o` are never high together.
- R3: Left shifts (codes 0 and 1) fill with zeros. Code 0 leaves the extension unchanged. Carry ends equal to the last bit shifted out of accumulator bit 15. A count of 0 leaves carry and data unchanged.
- R4: Normalize (code 2) shifts the pair left. It stops when accumulator bit 15 is 1 while the counter is non-zero. It then ends with carry 1 and the remaining counter value on `count_o`.
- R5: When normalize ends because the counter reached 0, carry is 0 even if accumulator bit 15 is then 1, and `count_o` is 0. A count of 0 gives carry 0 with the data unchanged.
- R6: Pair right shift (code 3) fills from the accumulator sign bit. Carry is unchanged.
- R7: Rotate right (code 4) moves extension bit 0 into accumulator bit 15 and accumulator bit 0 into extension bit 15. Carry is unchanged.
- R8: `ovf_o` takes `ovf_i` at the accepting edge and holds it through the run and until the next accepted start.
- R9: A `start_i` pulse while `busy_o` is high has no effect on the run in progress.
- R10: After reset, `busy_o`, `done_o`, `acc_o`, `ext_o`, `carry_o`, `ovf_o` and `count_o` are all 0.
- R11: Codes 5 to 7 end after one busy cycle. Data and carry are unchanged, and `count_o` equals the loaded count.
- R12: Codes 0, 1, 3 and 4 always end with `count_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a run when idle |
| op_i | input | 3 | Operation code |
| use_reg_i | input | 1 | 1 selects the index-register count |
| disp_cnt_i | input | 6 | Low bits of the instruction displacement |
| idx_cnt_i | input | 6 | Low bits of the selected index register |
| acc_i | input | 16 | Accumulator value at start |
| ext_i | input | 16 | Extension value at start |
| carry_i | input | 1 | Carry indicator at start |
| ovf_i | input | 1 | Overflow indicator at start |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| acc_o | output | 16 | Accumulator result |
| ext_o | output | 16 | Extension result |
| carry_o | output | 1 | Carry indicator result |
| ovf_o | output | 1 | Overflow indicator, unchanged |
| count_o | output | 6 | Residual counter value |

## Verification
In the normalize operation, the leading-one stop and counter exhaustion can fall on the same busy cycle. This happens when the count equals the number of leading zeros in the pair. In that case the counter test takes priority and carry must read 0 with the top bit set.

The sweep creates this coincidence by building pairs with a chosen leading-zero count and pairing them with every count from 0 to 63. Directed cases add the exact-match case with carry entering as 1. Each outcome is judged against a model in the bench that computes the stop point from the leading-zero count and the shift results arithmetically.

// File: rtl/shift_pkg.sv
// Shared types for the counted shifter: operation codes and sequencer states.
// Assumes a 3-bit operation field; codes outside the enum are treated as no-ops.
package shift_pkg;

    typedef enum logic [2:0] {
        OP_ACC_LEFT   = 3'd0,
        OP_PAIR_LEFT  = 3'd1,
        OP_NORMALIZE  = 3'd2,
        OP_PAIR_RIGHT = 3'd3,
        OP_PAIR_ROTR  = 3'd4
    } shift_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // True for codes that the datapath acts on.
    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

endpackage

// File: rtl/shift_count_sel.sv
// Chooses the shift count source: displacement bits or index register bits.
// Assumes both sources are already trimmed to the counter width by the caller.
module shift_count_sel #(
    parameter int CW = 6
) (
    input  logic          use_reg_i,
    input  logic [CW-1:0] disp_cnt_i,
    input  logic [CW-1:0] idx_cnt_i,
    output logic [CW-1:0] count_o
);

    // Source multiplexer for the count.
    always_comb begin
        count_o = use_reg_i ? idx_cnt_i : disp_cnt_i;
    end

endmodule

// File: rtl/shift_step.sv
// One-position shift of the accumulator/extension pair for a given operation.
// Pure combinational; the carry is touched only by the plain left shifts here,
// the normalize carry is settled by the sequencer at the end of the run.
module shift_step
    import shift_pkg::*;
#(
    parameter int DW = 16
) (
    input  shift_op_e     op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] ext_i,
    input  logic          carry_i,
    output logic [DW-1:0] acc_o,
    output logic [DW-1:0] ext_o,
    output logic          carry_o
);

    localparam int MSB = DW - 1;

    // Next pair and carry after one shift position.
    always_comb begin
        acc_o   = acc_i;
        ext_o   = ext_i;
        carry_o = carry_i;
        case (op_i)
            OP_ACC_LEFT: begin
                acc_o   = {acc_i[MSB-1:0], 1'b0};
                carry_o = acc_i[MSB];
            end
            OP_PAIR_LEFT: begin
                {acc_o, ext_o} = {acc_i[MSB-1:0], ext_i, 1'b0};
                carry_o        = acc_i[MSB];
            end
            OP_NORMALIZE: begin
                {acc_o, ext_o} = {acc_i[MSB-1:0], ext_i, 1'b0};
            end
            OP_PAIR_RIGHT: begin
                {acc_o, ext_o} = {acc_i[MSB], acc_i, ext_i[MSB:1]};
            end
            OP_PAIR_ROTR: begin
                {acc_o, ext_o} = {ext_i[0], acc_i, ext_i[MSB:1]};
            end
            default: begin
                acc_o   = acc_i;
                ext_o   = ext_i;
                carry_o = carry_i;
            end
        endcase
    end

endmodule

// File: rtl/shift_ctrl.sv
// Sequencer: holds the cycle-control counter, decides each cycle whether to
// shift or to finish, and raises the one-cycle done pulse.
// Assumes the count-zero test takes priority over the leading-one test.
module shift_ctrl
    import shift_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] count_i,
    input  shift_op_e     op_q_i,
    input  logic          acc_msb_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          load_o,
    output logic          step_o,
    output logic          finish_o,
    output logic          cnt_zero_o,
    output logic [CW-1:0] count_o
);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          msb_stop;

    // Stop conditions evaluated on the held operation and counter.
    always_comb begin
        cnt_zero_o = (cnt_q == '0);
        msb_stop   = (op_q_i == OP_NORMALIZE) && acc_msb_i;
        finish_o   = (state_q == ST_RUN) &&
                     (cnt_zero_o || msb_stop || !op_known(op_q_i));
        step_o     = (state_q == ST_RUN) && !finish_o;
        load_o     = (state_q == ST_IDLE) && start_i;
    end

    // State, counter and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                state_q <= ST_RUN;
                cnt_q   <= count_i;
            end else if (finish_o) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
            end else if (step_o) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy_o  = (state_q == ST_RUN);
    assign done_o  = done_q;
    assign count_o = cnt_q;

endmodule

// File: rtl/shift_seq_unit.sv
// Counted shifter top: captures operands on start, steps the pair one bit per
// cycle under the sequencer, and settles the normalize carry at the end.
// Assumes the caller holds operands valid only on the accepting edge.
module shift_seq_unit
    import shift_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [2:0]    op_i,
    input  logic          use_reg_i,
    input  logic [CW-1:0] disp_cnt_i,
    input  logic [CW-1:0] idx_cnt_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] ext_i,
    input  logic          carry_i,
    input  logic          ovf_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] acc_o,
    output logic [DW-1:0] ext_o,
    output logic          carry_o,
    output logic          ovf_o,
    output logic [CW-1:0] count_o
);

    logic [CW-1:0] sel_count;
    logic          load, step, finish, cnt_zero;
    shift_op_e     op_q;
    logic [DW-1:0] acc_q, ext_q, acc_nx, ext_nx;
    logic          carry_q, carry_nx, ovf_q;

    shift_count_sel #(.CW(CW)) i_count_sel (
        .use_reg_i (use_reg_i),
        .disp_cnt_i(disp_cnt_i),
        .idx_cnt_i (idx_cnt_i),
        .count_o   (sel_count)
    );

    shift_ctrl #(.CW(CW)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .count_i   (sel_count),
        .op_q_i    (op_q),
        .acc_msb_i (acc_q[DW-1]),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .load_o    (load),
        .step_o    (step),
        .finish_o  (finish),
        .cnt_zero_o(cnt_zero),
        .count_o   (count_o)
    );

    shift_step #(.DW(DW)) i_step (
        .op_i   (op_q),
        .acc_i  (acc_q),
        .ext_i  (ext_q),
        .carry_i(carry_q),
        .acc_o  (acc_nx),
        .ext_o  (ext_nx),
        .carry_o(carry_nx)
    );

    // Working registers: load on start, shift on step, normalize carry on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_ACC_LEFT;
            acc_q   <= '0;
            ext_q   <= '0;
            carry_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (load) begin
            op_q    <= shift_op_e'(op_i);
            acc_q   <= acc_i;
            ext_q   <= ext_i;
            carry_q <= carry_i;
            ovf_q   <= ovf_i;
        end else if (step) begin
            acc_q   <= acc_nx;
            ext_q   <= ext_nx;
            carry_q <= carry_nx;
        end else if (finish && op_q == OP_NORMALIZE) begin
            carry_q <= !cnt_zero;
        end
    end

    assign acc_o   = acc_q;
    assign ext_o   = ext_q;
    assign carry_o = carry_q;
    assign ovf_o   = ovf_q;

endmodule

// File: rtl/shift_seq_unit_chk.sv
// Property checker for the counted shifter, attached by bind.
// Assumes synchronous active-low reset held for at least one edge at start.
module shift_seq_unit_chk
    import shift_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          ovf_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [DW-1:0] acc_o,
    input logic          carry_o,
    input logic          ovf_o,
    input logic [CW-1:0] count_o,
    input logic [2:0]    op_q
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(ovf_o)); // R8
    AST_OVF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (ovf_o == $past(ovf_i))); // R8
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(op_q)); // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (count_o == $past(count_o)) ||
                   (count_o == $past(count_o) - CW'(1))); // R2
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2
    AST_NORM_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_NORMALIZE) |-> (carry_o == (count_o != '0))); // R4
    AST_NORM_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_NORMALIZE && carry_o) |-> acc_o[DW-1]); // R4
    AST_PLAIN_EXHAUST: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_known(op_q) && op_q != OP_NORMALIZE) |-> (count_o == '0)); // R12
    AST_RIGHT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (op_q == OP_PAIR_RIGHT || op_q == OP_PAIR_ROTR)) |=> $stable(carry_o)); // R6

endmodule

bind shift_seq_unit shift_seq_unit_chk #(.DW(DW), .CW(CW)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .ovf_i  (ovf_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .acc_o  (acc_o),
    .carry_o(carry_o),
    .ovf_o  (ovf_o),
    .count_o(count_o),
    .op_q   (op_q)
);

// File: tb/test_shift_seq_unit.sv
`timescale 1ns/1ps
module test_shift_seq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic        use_reg_i = 1'b0;
    logic [5:0]  disp_cnt_i = '0, idx_cnt_i = '0;
    logic [15:0] acc_i = '0, ext_i = '0;
    logic        carry_i = 1'b0, ovf_i = 1'b0;
    logic        busy_o, done_o, carry_o, ovf_o;
    logic [15:0] acc_o, ext_o;
    logic [5:0]  count_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    shift_seq_unit i_shift_seq_unit (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int lead_zeros(input logic [31:0] v);
        if (v == 32'd0) return 64;
        for (int i = 31; i >= 0; i--) if (v[i]) return 31 - i;
        return 64;
    endfunction

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    // Runs one operation and compares against an arithmetic model.
    task automatic run_op(input logic [2:0] op, input int n, input logic use_reg,
                          input logic [15:0] acc, input logic [15:0] ext,
                          input logic cin, input logic ovf, input logic poke);
        logic [31:0] pair, res;
        logic [63:0] w;
        logic signed [31:0] sp;
        logic ec;
        int s, cnt, lz, lat;
        string rq;
        pair = {acc, ext};
        ec = cin; s = n; cnt = 0; res = pair;
        case (op)
            3'd0: begin w = {48'd0, acc} << n; res = {w[15:0], ext};
                  if (n != 0) ec = w[16]; rq = "R3"; end
            3'd1: begin w = {32'd0, pair} << n; res = w[31:0];
                  if (n != 0) ec = w[32]; rq = "R3"; end
            3'd2: begin lz = lead_zeros(pair);
                  if (n > lz) begin s = lz; cnt = n - lz; ec = 1'b1; rq = "R4"; end
                  else begin s = n; ec = 1'b0; rq = "R5"; end
                  res = pair << s; end
            3'd3: begin sp = $signed(pair); res = sp >>> n; rq = "R6"; end
            3'd4: begin w = {pair, pair} >> (n % 32); res = w[31:0]; rq = "R7"; end
            default: begin s = 0; cnt = n; rq = "R11"; end
        endcase
        @(negedge clk);
        start_i = 1'b1; op_i = op; use_reg_i = use_reg;
        if (use_reg) begin idx_cnt_i = 6'(n); disp_cnt_i = 6'(~n); end
        else begin disp_cnt_i = 6'(n); idx_cnt_i = 6'(n + 17); end
        acc_i = acc; ext_i = ext; carry_i = cin; ovf_i = ovf;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0; ovf_i = ~ovf; acc_i = ~acc; carry_i = ~cin;
        lat = 0;
        while (!done_o && lat < 200) begin
            @(posedge clk); lat++; @(negedge clk);
            if (poke && lat == 1) begin start_i = 1'b1; op_i = 3'd7; acc_i = 16'h5A5A; end
            if (poke && lat == 2) start_i = 1'b0;
        end
        chk(rq, "acc", {16'd0, acc_o}, {16'd0, res[31:16]});
        chk(rq, "ext", {16'd0, ext_o}, {16'd0, res[15:0]});
        chk(rq, "carry", {31'd0, carry_o}, {31'd0, ec});
        chk((op > 3'd4) ? "R11" : (op == 3'd2 ? "R4" : "R12"), "count",
            {26'd0, count_o}, 32'(cnt));
        chk("R2", "latency", 32'(lat), 32'(s + 1));
        chk("R8", "ovf", {31'd0, ovf_o}, {31'd0, ovf});
        chk("R1", "busy_after_done", {31'd0, busy_o}, 32'd0);
        if (poke) chk("R9", "poke_busy", {31'd0, busy_o}, 32'd0);
        @(negedge clk);
        chk("R2", "done_pulse_width", {31'd0, done_o}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r, pr;
        int lzt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10", "busy", {31'd0, busy_o}, 32'd0);
        chk("R10", "done", {31'd0, done_o}, 32'd0);
        chk("R10", "acc_ext", {acc_o, ext_o}, 32'd0);
        chk("R10", "flags", {29'd0, carry_o, ovf_o, 1'b0}, 32'd0);
        chk("R10", "count", {26'd0, count_o}, 32'd0);
        // R5: count equals leading zeros, carry in 1, must end at 0 with top bit set
        run_op(3'd2, 4, 1'b0, 16'h0F00, 16'h1234, 1'b1, 1'b1, 1'b0);
        chk("R5", "top_bit", {31'd0, acc_o[15]}, 32'd1);
        // R4: top bit already set, stops at once with full residual
        run_op(3'd2, 10, 1'b1, 16'h8001, 16'h0000, 1'b0, 1'b0, 1'b0);
        // R5: zero count with carry in 1
        run_op(3'd2, 0, 1'b0, 16'h0001, 16'h0000, 1'b1, 1'b0, 1'b0);
        // R9: start while busy is ignored
        run_op(3'd1, 9, 1'b1, 16'h1357, 16'h9BDF, 1'b0, 1'b1, 1'b1);
        run_op(3'd4, 20, 1'b0, 16'h0001, 16'h8000, 1'b1, 1'b0, 1'b1);
        // R1..R12: sweep of every code, every count, three pair patterns
        for (int op = 0; op < 8; op++) begin
            for (int n = 0; n < 64; n++) begin
                for (int p = 0; p < 3; p++) begin
                    r = next_rand();
                    if (op == 2) begin
                        lzt = (n * 7 + p * 5) % 34;
                        pr = (lzt >= 32) ? 32'd0 :
                             ((32'h8000_0000 >> lzt) | (r & (32'h7FFF_FFFF >> lzt)));
                    end else begin
                        pr = r;
                    end
                    run_op(3'(op), n, 1'((n + p) % 2), pr[31:16], pr[15:0],
                           r[5], r[9], 1'b0);
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule